// File: doc/BRIEF.md
# Two-Level Interrupt Source Scanner

The scanner turns one processor interrupt request, identified by its priority level, into a series of encoded interrupt vectors. Each vector goes to a handler, one at a time. A small fixed table turns the priority level into a bus interrupt level. Level 0 marks an interrupt that is local to the processor. For such a request the priority level itself is handed to the handler and no bus is touched.

For a bus level from 1 to 7 the scanner first reads a pending-bus mask and writes the captured value back as a clear. It then visits each flagged bus in ascending order. For each one it reads that bus's slot-state word and keeps only the four slot bits that belong to the active level. For every pending slot, lowest first, it presents a vector that packs bus, level and slot, and holds it until the handler acknowledges. It then releases that single slot bit at the bus. When all buses and slots are done, it raises a one-cycle done pulse.

Every register access is a one-cycle request strobe. Read data is expected on the data input during the cycle that follows the strobe.

Top module: `intr_scanner`

## Requirements
- R1: The priority level maps to a bus level as follows: 2→1, 3→2, 5→3, 7→4, 9→5, 11→6, 13→7, and every other value →0. The mapped level is driven on `mask_lvl_o` with each mask read.
- R2: When the mapped level is 0, the block presents the priority level, zero-extended, as the vector. It then completes with no mask or slot access.
- R3: Only bits 17:0 of the pending-bus mask read data are used; bus index n is bit n, and higher bits have no effect on any access or vector.
- R4: After the mask read, the captured 18-bit mask is written back on `mask_wdata_o` with a `mask_clr_o` strobe. This happens before any slot-state read.
- R5: Buses whose mask bit is 1 are each read once, in ascending index order. Buses whose bit is 0 get no read.
- R6: Of the slot-state read data, only bits level×4+3 down to level×4 are used, with slot s at bit level×4+s. All other bits are ignored.
- R7: The pending slots of a bus are presented in ascending slot order.
- R8: The bus vector equals ((bus+1)<<5) | (level<<2) | slot.
- R9: A vector stays valid and unchanged until `vec_ack_i`. After the acknowledge, one `slot_rel_o` strobe carries the single bit level×4+slot on `slot_wdata_o` for that bus.
- R10: After the last slot or local vector, `done_o` pulses high for one cycle. `busy_o` stays high from start until the pulse.
- R11: A `start_i` pulse while `busy_o` is high is ignored.
- R12: Each access strobe lasts one cycle. Read data is taken from the cycle right after the strobe, and data in any other cycle is ignored.
- R13: In reset and after reset, all strobes, `vec_valid_o`, `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan for `pil_i` |
| pil_i | input | 4 | Processor interrupt priority level |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mask_rd_o | output | 1 | Pending-bus mask read strobe |
| mask_clr_o | output | 1 | Pending-bus mask clear strobe |
| mask_lvl_o | output | 3 | Bus level addressed by mask accesses |
| mask_wdata_o | output | 18 | Bits to clear in the mask |
| mask_rdata_i | input | 32 | Mask read data, one cycle after the strobe |
| slot_rd_o | output | 1 | Slot-state read strobe |
| slot_rel_o | output | 1 | Slot release strobe |
| slot_bus_o | output | 5 | Bus index for slot accesses |
| slot_wdata_o | output | 32 | Single release bit |
| slot_rdata_i | input | 32 | Slot-state read data, one cycle after the strobe |
| vec_valid_o | output | 1 | Vector valid |
| vec_o | output | 10 | Encoded interrupt vector |
| vec_ack_i | input | 1 | Handler acknowledge |

## Verification
A sweep over all sixteen priority levels, each with one pending bus carrying all slots, separates the mapped levels from the local ones. It also shows the level field of the vector and the group position in the release bit.

Further cases each probe one point:
- Masks with junk in the upper bits and gaps between flagged buses show whether unused mask bits are ignored and skipped buses get no read.
- Slot words with bits set outside the active group show that those bits are discarded.
- A bus that is flagged but has an empty group, together with a start pulse during a scan, shows that skipping and start rejection both work.

Read data is junk in every cycle except the one after a strobe, which exposes a wrong latency. Acknowledge delays of zero and several cycles show that the vector is held until accepted.

// File: rtl/intr_scan_pkg.sv
package intr_scan_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_MREQ, ST_MCAP, ST_MCLR, ST_BSEL, ST_SREQ,
    ST_SCAP, ST_SSEL, ST_VEC, ST_REL, ST_LVEC, ST_FIN
  } scan_state_e;
endpackage

// File: rtl/pil_level_map.sv
module pil_level_map #(
  parameter int PIL_W = 4,
  parameter int LVL_W = 3
) (
  input  logic [PIL_W-1:0] pil_i,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    case (pil_i)
      PIL_W'(2):  lvl_o = LVL_W'(1);
      PIL_W'(3):  lvl_o = LVL_W'(2);
      PIL_W'(5):  lvl_o = LVL_W'(3);
      PIL_W'(7):  lvl_o = LVL_W'(4);
      PIL_W'(9):  lvl_o = LVL_W'(5);
      PIL_W'(11): lvl_o = LVL_W'(6);
      PIL_W'(13): lvl_o = LVL_W'(7);
      default:    lvl_o = '0;
    endcase
  end
endmodule

// File: rtl/lowest_set.sv
module lowest_set #(
  parameter int W = 4,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intr_scanner.sv
module intr_scanner
  import intr_scan_pkg::*;
#(
  parameter int NUM_BUS = 18,
  parameter int SLOTS   = 4,
  parameter int DATA_W  = 32,
  parameter int PIL_W   = 4,
  parameter int LVL_W   = 3,
  localparam int BUS_W  = $clog2(NUM_BUS),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BNUM_W = $clog2(NUM_BUS + 1),
  localparam int VEC_W  = BNUM_W + LVL_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PIL_W-1:0]  pil_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mask_rd_o,
  output logic              mask_clr_o,
  output logic [LVL_W-1:0]  mask_lvl_o,
  output logic [NUM_BUS-1:0] mask_wdata_o,
  input  logic [DATA_W-1:0] mask_rdata_i,
  output logic              slot_rd_o,
  output logic              slot_rel_o,
  output logic [BUS_W-1:0]  slot_bus_o,
  output logic [DATA_W-1:0] slot_wdata_o,
  input  logic [DATA_W-1:0] slot_rdata_i,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              vec_ack_i
);
  scan_state_e        state_q;
  logic [PIL_W-1:0]   pil_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [NUM_BUS-1:0] bus_pend_q;
  logic [BUS_W-1:0]   bus_q;
  logic [SLOTS-1:0]   slot_pend_q;
  logic [SLOT_W-1:0]  slot_q;

  logic [LVL_W-1:0]   lvl_map;
  logic               bus_any, slot_any;
  logic [BUS_W-1:0]   bus_idx;
  logic [SLOT_W-1:0]  slot_idx;
  logic [DATA_W-1:0]  grp_shift;
  logic [DATA_W-1:0]  unused_mask_hi;

  pil_level_map #(.PIL_W(PIL_W), .LVL_W(LVL_W)) u_map (
    .pil_i (pil_i),
    .lvl_o (lvl_map)
  );

  lowest_set #(.W(NUM_BUS)) u_bus_pick (
    .vec_i (bus_pend_q),
    .any_o (bus_any),
    .idx_o (bus_idx)
  );

  lowest_set #(.W(SLOTS)) u_slot_pick (
    .vec_i (slot_pend_q),
    .any_o (slot_any),
    .idx_o (slot_idx)
  );

  assign grp_shift      = slot_rdata_i >> (int'(lvl_q) * SLOTS);
  assign unused_mask_hi = mask_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pil_q       <= '0;
      lvl_q       <= '0;
      bus_pend_q  <= '0;
      bus_q       <= '0;
      slot_pend_q <= '0;
      slot_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          pil_q   <= pil_i;
          lvl_q   <= lvl_map;
          state_q <= (lvl_map == '0) ? ST_LVEC : ST_MREQ;
        end
        ST_MREQ: state_q <= ST_MCAP;
        ST_MCAP: begin
          bus_pend_q <= mask_rdata_i[NUM_BUS-1:0];
          state_q    <= ST_MCLR;
        end
        ST_MCLR: state_q <= ST_BSEL;
        ST_BSEL: if (bus_any) begin
          bus_q   <= bus_idx;
          state_q <= ST_SREQ;
        end else begin
          state_q <= ST_FIN;
        end
        ST_SREQ: state_q <= ST_SCAP;
        ST_SCAP: begin
          slot_pend_q <= grp_shift[SLOTS-1:0];
          state_q     <= ST_SSEL;
        end
        ST_SSEL: if (slot_any) begin
          slot_q  <= slot_idx;
          state_q <= ST_VEC;
        end else begin
          bus_pend_q[bus_q] <= 1'b0;
          state_q           <= ST_BSEL;
        end
        ST_VEC:  if (vec_ack_i) state_q <= ST_REL;
        ST_REL: begin
          slot_pend_q[slot_q] <= 1'b0;
          state_q             <= ST_SSEL;
        end
        ST_LVEC: if (vec_ack_i) state_q <= ST_FIN;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign mask_rd_o    = (state_q == ST_MREQ);
  assign mask_clr_o   = (state_q == ST_MCLR);
  assign mask_lvl_o   = lvl_q;
  assign mask_wdata_o = bus_pend_q;
  assign slot_rd_o    = (state_q == ST_SREQ);
  assign slot_rel_o   = (state_q == ST_REL);
  assign slot_bus_o   = bus_q;
  assign slot_wdata_o = DATA_W'(1) << (int'(lvl_q) * SLOTS + int'(slot_q));
  assign vec_valid_o  = (state_q == ST_VEC) || (state_q == ST_LVEC);

  always_comb begin
    if (state_q == ST_LVEC) vec_o = VEC_W'(pil_q);
    else vec_o = {BNUM_W'(bus_q) + BNUM_W'(1), lvl_q, slot_q};
  end
endmodule

// File: rtl/intr_scanner_chk.sv
module intr_scanner_chk #(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 3,
  parameter int SLOTS  = 4,
  parameter int VEC_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              mask_rd_o,
  input logic              mask_clr_o,
  input logic [LVL_W-1:0]  mask_lvl_o,
  input logic              slot_rd_o,
  input logic              slot_rel_o,
  input logic [DATA_W-1:0] slot_wdata_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              vec_ack_i
);
  logic [DATA_W-1:0] grp_mask;
  assign grp_mask = ((DATA_W'(1) << SLOTS) - DATA_W'(1)) << (int'(mask_lvl_o) * SLOTS);

  a_r9_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && !vec_ack_i |=> vec_valid_o && $stable(vec_o));
  a_r9_rel_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rel_o |-> $countones(slot_wdata_o) == 1);
  a_r6_rel_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rel_o |-> (slot_wdata_o & ~grp_mask) == '0);
  a_r4_clr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_clr_o |-> $past(mask_rd_o, 2));
  a_r12_mask_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_rd_o |=> !mask_rd_o);
  a_r12_slot_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rd_o |=> !slot_rd_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  a_r13_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mask_rd_o, mask_clr_o, slot_rd_o, slot_rel_o, vec_valid_o, done_o}));
endmodule

bind intr_scanner intr_scanner_chk #(
  .DATA_W(DATA_W), .LVL_W(LVL_W), .SLOTS(SLOTS), .VEC_W(VEC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mask_rd_o    (mask_rd_o),
  .mask_clr_o   (mask_clr_o),
  .mask_lvl_o   (mask_lvl_o),
  .slot_rd_o    (slot_rd_o),
  .slot_rel_o   (slot_rel_o),
  .slot_wdata_o (slot_wdata_o),
  .vec_valid_o  (vec_valid_o),
  .vec_o        (vec_o),
  .vec_ack_i    (vec_ack_i)
);

// File: tb/intr_scanner_test.sv
module intr_scanner_test;
  localparam int NB = 18;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  pil_i = '0;
  logic        busy_o, done_o, mask_rd_o, mask_clr_o, slot_rd_o, slot_rel_o, vec_valid_o;
  logic [2:0]  mask_lvl_o;
  logic [17:0] mask_wdata_o;
  logic [31:0] mask_rdata_i = 32'hdead_beef;
  logic [4:0]  slot_bus_o;
  logic [31:0] slot_wdata_o;
  logic [31:0] slot_rdata_i = 32'hdead_beef;
  logic [9:0]  vec_o;
  logic        vec_ack_i = 1'b0;

  intr_scanner uut (.*);

  always #5 clk_i = ~clk_i;

  int compared = 0, mismatched = 0;
  logic [31:0] bmask;
  logic [31:0] smem [NB];
  int   exp_kind [$];
  longint exp_val [$];
  bit   done_seen = 0, mrd_prev = 0, srd_prev = 0;
  logic [4:0] srd_bus;
  int   ack_delay = 0, ack_cnt = 0;
  int   lvl_tab [16] = '{0,0,1,2,0,3,0,4,0,5,0,6,0,7,0,0};

  function automatic string tag(int k);
    case (k)
      1: return "R1 mask read level";
      2: return "R4/R3 mask clear";
      3: return "R5 slot read order";
      4: return "R8/R7/R2 vector";
      5: return "R9/R6 slot release";
      default: return "R10 done";
    endcase
  endfunction

  task automatic check_event(int k, longint v);
    compared++;
    if (exp_kind.size() == 0) begin
      mismatched++;
      $display("FAIL %s: unexpected event kind %0d val %0h, expected none", tag(k), k, v);
    end else begin
      int ek = exp_kind.pop_front();
      longint ev = exp_val.pop_front();
      if (ek != k || ev != v) begin
        mismatched++;
        $display("FAIL %s: actual kind %0d val %0h, expected kind %0d val %0h", tag(ek), k, v, ek, ev);
      end
    end
  endtask

  task automatic check_eq(string t, longint a, longint e);
    compared++;
    if (a != e) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", t, a, e);
    end
  endtask

  // observation and bus/handler responder, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      mask_rdata_i <= mrd_prev ? bmask : 32'hdead_beef;
      slot_rdata_i <= srd_prev ? smem[srd_bus] : 32'hdead_beef;
      mrd_prev = mask_rd_o;
      srd_prev = slot_rd_o;
      srd_bus  = slot_bus_o;
      if (mask_rd_o) check_event(1, longint'(mask_lvl_o));
      if (mask_clr_o) begin
        check_event(2, longint'(mask_wdata_o));
        bmask = bmask & ~{14'd0, mask_wdata_o};
      end
      if (slot_rd_o) check_event(3, longint'(slot_bus_o));
      if (slot_rel_o) begin
        check_event(5, (longint'(slot_bus_o) << 32) | longint'(slot_wdata_o));
        smem[slot_bus_o] = smem[slot_bus_o] & ~slot_wdata_o;
      end
      if (done_o) begin
        check_event(6, 0);
        done_seen = 1;
      end
      if (vec_ack_i) vec_ack_i <= 1'b0;
      else if (vec_valid_o) begin
        if (ack_cnt >= ack_delay) begin
          check_event(4, longint'(vec_o));
          vec_ack_i <= 1'b1;
          ack_cnt = 0;
        end else ack_cnt++;
      end
    end
  end

  task automatic push(int k, longint v);
    exp_kind.push_back(k);
    exp_val.push_back(v);
  endtask

  task automatic build(int pil);
    int lvl = lvl_tab[pil];
    logic [17:0] m;
    if (lvl == 0) begin
      push(4, pil);
    end else begin
      push(1, lvl);
      m = bmask[17:0];
      push(2, m);
      for (int b = 0; b < NB; b++) begin
        if (m[b]) begin
          logic [3:0] g;
          push(3, b);
          g = 4'((smem[b] >> (lvl * 4)) & 32'hf);
          for (int s = 0; s < 4; s++)
            if (g[s]) begin
              push(4, ((b + 1) << 5) | (lvl << 2) | s);
              push(5, (longint'(b) << 32) | longint'(32'd1 << (lvl * 4 + s)));
            end
        end
      end
    end
    push(6, 0);
  endtask

  task automatic run_case(string name, int pil, int delay, bit mid_start);
    ack_delay = delay;
    ack_cnt = 0;
    done_seen = 0;
    build(pil);
    @(negedge clk_i);
    pil_i = 4'(pil);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (mid_start) begin
      repeat (6) @(negedge clk_i);
      check_eq({name, " R10 busy during scan"}, busy_o, 1);
      pil_i = 4'd4;  // R11: start while busy must be ignored
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int i = 0; i < 400 && !done_seen; i++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check_eq({name, " R10/R11 all events seen"}, exp_kind.size(), 0);
    check_eq({name, " R10 idle after done"}, busy_o, 0);
    exp_kind.delete();
    exp_val.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) smem[b] = 32'h0;
    bmask = 32'h0;
    repeat (3) @(negedge clk_i);
    // R13: reset state
    check_eq("R13 reset strobes", {busy_o, done_o, mask_rd_o, mask_clr_o, slot_rd_o, slot_rel_o, vec_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_eq("R13 idle after reset", {busy_o, done_o, mask_rd_o, mask_clr_o, slot_rd_o, slot_rel_o, vec_valid_o}, 0);

    // R1/R2: sweep all priority levels, one bus with every slot set
    for (int p = 0; p < 16; p++) begin
      bmask = 32'h1;
      smem[0] = 32'hffff_ffff;
      run_case("sweep", p, p % 3, 0);
    end

    // R3/R5/R6: junk high mask bits, gaps, bits outside group
    bmask = 32'hfffc_0005;
    smem[0] = 32'hf00f_f0af;
    smem[1] = 32'hffff_ffff;
    smem[2] = 32'h0000_0010;
    run_case("gaps lvl1", 2, 0, 0);

    // R7/R8: highest bus, level 7, all slots
    bmask = 32'h0002_0000;
    smem[17] = 32'hf000_0000;
    run_case("top bus lvl7", 13, 1, 0);

    // R5/R11: flagged bus with empty group, start while busy
    bmask = 32'h0000_0028;
    smem[3] = 32'h000f_ffff;
    smem[5] = 32'h0080_0000;
    run_case("empty group lvl5", 9, 2, 1);

    // R4: empty mask, only read and clear
    bmask = 32'hfffc_0000;
    run_case("empty mask", 7, 0, 0);

    // R2/R11: local vector with start while busy and slow ack
    run_case("local", 14, 5, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule